// File: doc/BRIEF.md
# Register-Mapped SPI Byte Master

This block is a single-chip-select SPI master that sits behind a simple 32-bit register bus. Software sets the serial clock rate and the SPI mode (clock polarity and phase) in a control register. It drives the chip-select line by hand through a bit in a system control register. Each write to the transmit register starts the exchange of one byte, full duplex. The byte clocked in from the target lands in a receive register.

A byte moves as follows. Software polls the status register until the busy flag is low, then writes the next byte. It polls again until the receive-full flag is set and reads the received byte, which clears that flag. The serial clock comes from two prescaler stages. The first stage divides by a fixed 16 or 128. The second divides by an even amount, 2·(N+1), that software chooses. The shift engine takes a copy of the clock and mode settings when a byte starts, so later changes to the control register apply only from the next byte.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control register (offset 0x00) and the status register (0x04) read 0, the system control register (0x08) reads 0x40, `cs_n_o` is 1 and `sck_o` is 0.
- R2: Control bit 5 selects the first stage (1: ÷128, 0: ÷16) and bits 4:0 hold N. Each SCK half period lasts (bit5 ? 128 : 16)·(N+1) clock cycles.
- R3: Control bit 6 is CPOL, the idle SCK level, and bit 7 is CPHA. With CPHA=0, MISO is sampled on the leading SCK edges and MOSI changes on the trailing edges. With CPHA=1, MOSI changes on the leading edges (from the second one on) and MISO is sampled on the trailing edges. Bits go out and come in MSB first, eight per byte.
- R4: Status bit 0 (busy) is 1 from the cycle after an accepted write to the transmit register (0x0C) until the cycle in which receive-full is set. Busy then falls in that same cycle.
- R5: When a byte completes, status bit 2 (receive-full) is set and the byte is readable at 0x10 in bits 7:0, with bits 31:8 zero. A read of 0x10 clears receive-full.
- R6: A write to the status register with bit 2 equal to 0 clears receive-full.
- R7: A write to the transmit register while busy is 1 is ignored. It neither changes the byte in flight nor starts a further byte.
- R8: `cs_n_o` follows bit 6 of the last value written to the system control register, one cycle after the write. Writing 0x21 asserts chip select (low).
- R9: A control register write during a byte leaves that byte's clock rate and mode unchanged. Once idle, SCK moves to the newly written CPOL level.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Offset 0x14 reads 0, and the system control register reads back its last written value in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
The assertions assume the bus never raises `bus_wr` and `bus_rd` in the same cycle. They also assume every access uses one of the six word offsets, and that MISO changes only on the SCK edge opposite to the one the master samples on. The bench issues every bus access through tasks that raise one strobe for a single cycle at a time. Its target model drives MISO only from its own shift-edge branch, and it reprograms CPOL and CPHA only while the master is idle.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam int DIV_W = 5;

  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_SYS   = 2;
  localparam int IDX_TX    = 3;
  localparam int IDX_RX    = 4;
  localparam int IDX_CTRL2 = 5;

  localparam logic [7:0] SYS_RESET = 8'h40;

  typedef struct packed {
    logic             cpha;
    logic             cpol;
    logic             slow;
    logic [DIV_W-1:0] div_n;
  } ctrl_t;
endpackage

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import spi_bm_pkg::*;
#(
  parameter int LO_DIV = 16,
  parameter int HI_DIV = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             slow,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  localparam int BIG_DIV  = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
  localparam int MAX_HALF = BIG_DIV * (2 ** DIV_W);
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stage;
  logic [CNT_W-1:0] limit;

  always_comb begin
    stage = slow ? CNT_W'(HI_DIV) : CNT_W'(LO_DIV);
    limit = stage * (CNT_W'(div_n) + CNT_W'(1));
  end

  assign tick = run && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_bm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LO_DIV = 16,
  parameter int HI_DIV = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  ctrl_t             cfg,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic              busy_q, done_q, sck_q;
  logic              cpha_q, slow_q;
  logic [DIV_W-1:0]  divn_q;
  logic [EDGE_W-1:0] edge_k;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_q, rx_next;
  logic              tick, is_sample, is_shift, last_edge;

  spi_sck_divider #(.LO_DIV(LO_DIV), .HI_DIV(HI_DIV)) div_i (
    .clk   (clk),
    .rst   (rst),
    .run   (busy_q),
    .slow  (slow_q),
    .div_n (divn_q),
    .tick  (tick)
  );

  always_comb begin
    is_sample = cpha_q ? edge_k[0] : !edge_k[0];
    is_shift  = cpha_q ? (!edge_k[0] && (edge_k != '0)) : edge_k[0];
    last_edge = (edge_k == EDGE_W'(EDGES - 1));
    rx_next   = is_sample ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      cpha_q <= 1'b0;
      slow_q <= 1'b0;
      divn_q <= '0;
      edge_k <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sck_q <= cfg.cpol;
        if (start) begin
          busy_q <= 1'b1;
          tx_sh  <= tx_byte;
          rx_sh  <= '0;
          cpha_q <= cfg.cpha;
          slow_q <= cfg.slow;
          divn_q <= cfg.div_n;
          edge_k <= '0;
        end
      end else if (tick) begin
        sck_q  <= !sck_q;
        edge_k <= edge_k + EDGE_W'(1);
        rx_sh  <= rx_next;
        if (is_shift) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= rx_next;
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_sh[DATA_W-1];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LO_DIV = 16,
  parameter int HI_DIV = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o
);
  localparam int IDX_W = ADDR_W - 2;
  typedef logic [IDX_W-1:0] idx_t;

  idx_t        reg_idx;
  ctrl_t       ctrl_q;
  logic [7:0]  sys_q;
  logic [7:0]  rx_buf;
  logic        rx_full;
  logic [31:0] rdata_q;
  logic        eng_busy, eng_done, stat_busy, start;
  logic [7:0]  eng_rx;
  logic        wr_ctrl, wr_stat, wr_sys, wr_tx, rd_rx;
  logic        unused_bits;

  assign reg_idx     = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};

  always_comb begin
    wr_ctrl   = bus_wr && (reg_idx == idx_t'(IDX_CTRL));
    wr_stat   = bus_wr && (reg_idx == idx_t'(IDX_STAT));
    wr_sys    = bus_wr && (reg_idx == idx_t'(IDX_SYS));
    wr_tx     = bus_wr && (reg_idx == idx_t'(IDX_TX));
    rd_rx     = bus_rd && (reg_idx == idx_t'(IDX_RX));
    stat_busy = eng_busy || eng_done;
    start     = wr_tx && !stat_busy;
  end

  spi_shift_engine #(.DATA_W(8), .LO_DIV(LO_DIV), .HI_DIV(HI_DIV)) eng_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tx_byte (bus_wdata[7:0]),
    .cfg     (ctrl_q),
    .miso    (miso_i),
    .sck     (sck_o),
    .mosi    (mosi_o),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_byte (eng_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      sys_q   <= SYS_RESET;
      rx_buf  <= '0;
      rx_full <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
      if (wr_sys)  sys_q  <= bus_wdata[7:0];
      if (eng_done) begin
        rx_buf  <= eng_rx;
        rx_full <= 1'b1;
      end else if (rd_rx || (wr_stat && !bus_wdata[2])) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      rdata_q <= '0;
    end else begin
      case (reg_idx)
        idx_t'(IDX_CTRL): rdata_q <= {24'd0, ctrl_q};
        idx_t'(IDX_STAT): rdata_q <= {29'd0, rx_full, 1'b0, stat_busy};
        idx_t'(IDX_SYS):  rdata_q <= {24'd0, sys_q};
        idx_t'(IDX_RX):   rdata_q <= {24'd0, rx_buf};
        default:          rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign cs_n_o    = sys_q[6];
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              wd_cs,
  input logic              wd_full,
  input logic              stat_busy,
  input logic              eng_done,
  input logic              rx_full,
  input logic              cs_n_o
);
  logic [ADDR_W-3:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  // R8
  cs_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 2) |=> (cs_n_o == $past(wd_cs)));

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 3 && !stat_busy) |=> stat_busy);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_busy && !eng_done) |=> stat_busy);

  // R5
  full_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_busy) |-> rx_full);

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx == 4 && !eng_done) |=> !rx_full);

  // R6
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == 1 && !wd_full && !eng_done) |=> !rx_full);
endmodule

bind spi_byte_master spi_byte_master_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .wd_cs     (bus_wdata[6]),
  .wd_full   (bus_wdata[2]),
  .stat_busy (stat_busy),
  .eng_done  (eng_done),
  .rx_full   (rx_full),
  .cs_n_o    (cs_n_o)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam logic [23:0] VEC [0:5] = '{
    24'h00A53C, 24'h8196C3, 24'h420180, 24'hC0FF00, 24'h205AE7, 24'hC38001
  };

  logic clk = 0, rst = 1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sck_o, mosi_o, cs_n_o;
  logic miso_i = 0;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  logic       b_cpol = 0, b_cpha = 0;
  logic [7:0] s_resp = 0, s_got = 0;
  int         s_idx = 0, s_edges = 16;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  // target model: 16 edges per byte, then inert
  always @(sck_o) begin
    if (s_edges < 16) begin
      s_edges = s_edges + 1;
      if ((sck_o != b_cpol) == (b_cpha == 1'b0)) begin
        s_got = {s_got[6:0], mosi_o};
      end else if (s_idx < 8) begin
        miso_i = s_resp[7 - s_idx];
        s_idx  = s_idx + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic prepare(input logic [7:0] ctrl, input logic [7:0] resp);
    @(negedge clk);
    b_cpol = ctrl[6]; b_cpha = ctrl[7];
    s_resp = resp; s_got = 0; s_edges = 0;
    if (!ctrl[7]) begin miso_i = resp[7]; s_idx = 1; end
    else          begin s_idx = 0; end
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int n;
    n = 0;
    do begin
      rd(5'h04, st);
      n++;
    end while (st[0] && n < 20000);
  endtask

  task automatic xfer(input logic [7:0] ctrl, input logic [7:0] tx, input logic [7:0] resp);
    logic [31:0] v;
    wr(5'h00, {24'd0, ctrl});
    prepare(ctrl, resp);
    wr(5'h0C, {24'd0, tx});
    wait_idle();
    rd(5'h04, v);
    check(v == 32'h4, "R4 R5 status after byte", v, 32'h4);
    check(s_got == tx, "R3 MOSI byte seen by target", {24'd0, s_got}, {24'd0, tx});
    rd(5'h10, v);
    check(v == {24'd0, resp}, "R5 R3 received byte", v, {24'd0, resp});
    rd(5'h04, v);
    check(v == 32'h0, "R5 receive-full cleared by read", v, 32'h0);
  endtask

  task automatic measure_half(input logic [7:0] ctrl, input int exp);
    int n;
    logic [31:0] v;
    wr(5'h00, {24'd0, ctrl});
    prepare(ctrl, 8'h00);
    wr(5'h0C, 32'h0);
    while (sck_o == ctrl[6]) @(negedge clk);
    n = 0;
    while (sck_o != ctrl[6]) begin @(negedge clk); n++; end
    check(n == exp, "R2 SCK half period", n, exp);
    wait_idle();
    rd(5'h10, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog R4 actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(cs_n_o == 1'b1, "R1 cs_n after reset", {31'd0, cs_n_o}, 32'h1);
    check(sck_o == 1'b0, "R1 sck after reset", {31'd0, sck_o}, 32'h0);
    rd(5'h00, v); check(v == 0, "R1 control reset", v, 0);
    rd(5'h04, v); check(v == 0, "R1 status reset", v, 0);
    rd(5'h08, v); check(v == 32'h40, "R1 system control reset", v, 32'h40);

    // R8 chip select, R10 readback
    wr(5'h08, 32'h21);
    check(cs_n_o == 1'b0, "R8 cs asserted by 0x21", {31'd0, cs_n_o}, 32'h0);
    rd(5'h08, v); check(v == 32'h21, "R10 system control readback", v, 32'h21);
    rd(5'h14, v); check(v == 0, "R10 offset 0x14 reads zero", v, 0);

    // vector table: modes 0-3 and both prescaler stages (R2 R3 R4 R5)
    for (int i = 0; i < 6; i++) xfer(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

    // R2 half-period length
    measure_half(8'h01, 32);
    measure_half(8'h20, 128);
    measure_half(8'h43, 64);

    // R7 write while busy ignored
    wr(5'h00, 32'h00);
    prepare(8'h00, 8'h11);
    wr(5'h0C, 32'hC6);
    repeat (50) @(negedge clk);
    wr(5'h0C, 32'h39);
    wait_idle();
    check(s_got == 8'hC6, "R7 byte in flight kept", {24'd0, s_got}, 32'hC6);
    repeat (300) @(negedge clk);
    rd(5'h04, v); check(v == 32'h4, "R7 no second byte started", v, 32'h4);
    rd(5'h10, v); check(v == 32'h11, "R7 received byte", v, 32'h11);

    // R6 status write clears receive-full
    xfer(8'h00, 8'h3E, 8'h7D);
    wr(5'h0C, 32'h12);
    prepare(8'h00, 8'h55);
    wait_idle();
    rd(5'h04, v); check(v == 32'h4, "R6 receive-full before clear", v, 32'h4);
    wr(5'h04, 32'h0);
    rd(5'h04, v); check(v == 32'h0, "R6 status write clears flag", v, 32'h0);

    // R9 control change mid-byte
    wr(5'h00, 32'h00);
    prepare(8'h00, 8'hB4);
    wr(5'h0C, 32'h6B);
    repeat (40) @(negedge clk);
    wr(5'h00, 32'h43);
    wait_idle();
    check(s_got == 8'h6B, "R9 byte kept old mode", {24'd0, s_got}, 32'h6B);
    rd(5'h10, v); check(v == 32'hB4, "R9 received byte old mode", v, 32'hB4);
    check(sck_o == 1'b1, "R9 idle SCK takes new CPOL", {31'd0, sck_o}, 32'h1);

    // R8 release chip select
    wr(5'h08, 32'h61);
    check(cs_n_o == 1'b1, "R8 cs released", {31'd0, cs_n_o}, 32'h1);

    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule